// File: doc/BRIEF.md
# Display Controller Command Front End

This block sits at the host side of a graphics display controller. The host writes bytes to two ports, one for commands and one for parameters. Both ports feed one shared queue. Each queued entry is nine bits wide: a flag that marks a command, plus the data byte. A decoder takes entries from the head of the queue, one per clock cycle, in the order they arrived. It takes nothing while the drawing engine reports that it is busy.

The decoder interprets command opcodes and routes the parameter bytes that follow each command.

- A write-class command latches its opcode as the write mode. It then gathers fixed-size groups of data bytes, and each complete group raises a write strobe.
- A vector-setup command fills an eleven-byte draw parameter block.
- A figure-draw or text-draw command raises a draw strobe that carries the selected operations. It then restores the draw parameter block to its defaults.
- Four commands switch the display on or off.

A status byte combines the following: a constant one, a horizontal-blank indication worked out from raster timing inputs, vertical sync, the drawing flag, and the queue's empty and full flags.

The raster timing counters and the pixel drawing engine lie outside this block. They appear only as inputs, or as consumers of the strobes.

Top module: `disp_cmd_front`

## Requirements
- R1: A write on the command port queues an entry with its flag set; a write on the parameter port queues one with the flag clear. Entries are decoded in arrival order, one per cycle, and none is decoded while `drawing_in` is high. When both ports write in the same cycle, only the command entry is queued.
- R2: The queue holds 16 entries, and a write that arrives while it is full is discarded. Status bit 2 is 1 when the queue is empty, and status bit 1 is 1 when it is full.
- R3: A command with bits [6:5] = 01 is latched on `write_mode`. It restarts the gathering of write data groups of `WR_BYTES` (default 2) parameter bytes.
- R4: When a write data group completes, the byte count restarts. If the instance is the slave (default) and (`write_mode` & 0xE4) == 0x20, `write_strobe` pulses for one cycle with `write_data` = {last byte, ..., first byte}. Mode 0x24 gathers data but never pulses.
- R5: Command 0x4C (vector setup) directs the following parameter bytes into draw bytes 0 to 10, in order. Bytes past the eleventh are ignored. Draw byte i appears at `draw_par[8*i+7:8*i]`.
- R6: Command 0x6C (figure draw) or 0x68 (text draw) pulses `draw_strobe` for one cycle. `draw_text` = 1 only for 0x68. `draw_ops` = draw byte 0 bits [6:3], with bit 0 for line, bit 1 for text, bit 2 for arc and bit 3 for rectangle; any combination may be set.
- R7: After every draw, draw bytes 1 to 10 hold 00,00,08,00,08,00,FF,FF,FF,FF, and byte 0 keeps its value. Reset also loads these defaults, with byte 0 = 00.
- R8: The status bits are as follows. Bit 7 is always 1. Bit 5 is `vsync_in` and bit 3 is `drawing_in`. Bits 4 and 0 are 0. Bit 6 is 1 when `raster_period` is nonzero and (`frame_remain` mod `raster_period`) < `hsync_period`.
- R9: Commands 0x6B (start) and 0x0F (sync on) set `display_en`. Commands 0x0C (stop) and 0x0E (sync off) clear it. `display_en` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_wr | input | 1 | Write `wr_data` as a command entry |
| par_wr | input | 1 | Write `wr_data` as a parameter entry |
| wr_data | input | 8 | Byte written by either port |
| drawing_in | input | 1 | Drawing engine busy; holds the decoder |
| vsync_in | input | 1 | Vertical sync from raster timing |
| raster_period | input | TIME_W | Length of one raster line |
| hsync_period | input | TIME_W | Length of horizontal sync within a line |
| frame_remain | input | TIME_W | Time left in the current frame |
| status | output | 8 | Status byte |
| display_en | output | 1 | Display enabled |
| write_strobe | output | 1 | One-cycle pulse per completed write data group |
| write_mode | output | 8 | Latched write-class opcode |
| write_data | output | 8*WR_BYTES | Completed write data group |
| draw_strobe | output | 1 | One-cycle pulse per draw command |
| draw_text | output | 1 | Last draw was a text draw |
| draw_ops | output | 4 | Operations selected by the last draw |
| draw_par | output | 88 | Draw parameter bytes 0 to 10 |

## Verification
The assertions take for granted that `drawing_in` is a clean level. They also assume that no more than one port is written per cycle, except where priority between the ports is being exercised, and that the timing inputs change only between clock edges.

The directed stimulus drives every input at the falling clock edge. It raises `drawing_in` on purpose, so that the queue fills and writes are dropped, and it lowers it again before it expects any decoded effect. The bench predicts the dropped bytes from the queue depth alone, and it observes them through the write data that follows.

// File: rtl/disp_front_pkg.sv
// Package: shared opcodes, sizes and draw-parameter defaults for the
// display controller command front end.
package disp_front_pkg;

    localparam int          DRAW_BYTES   = 11;
    localparam logic [7:0]  OP_START     = 8'h6B;
    localparam logic [7:0]  OP_STOP      = 8'h0C;
    localparam logic [7:0]  OP_SYNC_ON   = 8'h0F;
    localparam logic [7:0]  OP_SYNC_OFF  = 8'h0E;
    localparam logic [7:0]  OP_VSETUP    = 8'h4C;
    localparam logic [7:0]  OP_FIGURE    = 8'h6C;
    localparam logic [7:0]  OP_TEXT      = 8'h68;
    localparam logic [7:0]  WR_MASK      = 8'hE4;
    localparam logic [7:0]  WR_MATCH     = 8'h20;

    // Where parameter bytes go after the most recent command
    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_WRITE,
        TGT_VSETUP
    } par_target_e;

    // Default value of draw byte idx, restored after each draw
    function automatic logic [7:0] draw_default(input int idx);
        if (idx == 3 || idx == 5)
            return 8'h08;
        else if (idx >= 7)
            return 8'hFF;
        else
            return 8'h00;
    endfunction

    // All draw bytes flattened, byte 0 lowest
    function automatic logic [8*DRAW_BYTES-1:0] draw_defaults_flat();
        logic [8*DRAW_BYTES-1:0] v;
        v = '0;
        for (int i = 0; i < DRAW_BYTES; i++)
            v[8*i +: 8] = draw_default(i);
        return v;
    endfunction

endpackage

// File: rtl/cmd_fifo.sv
// Module: cmd_fifo
// Flagged-entry queue shared by the command and parameter ports.
// Assumes DEPTH is a power of two. A push while full is discarded; a push
// and a pop in the same cycle are both honoured when the queue is not full.
module cmd_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Entry storage
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

endmodule

// File: rtl/front_decoder.sv
// Module: front_decoder
// Decodes one queued entry per valid cycle. It handles the display on/off
// commands, gathers write data groups, fills the draw parameter block and
// issues the draw strobes. Assumes entry bit 8 marks a command.
// IS_SLAVE = 0 suppresses the write and draw strobes.
module front_decoder
    import disp_front_pkg::*;
#(
    parameter int WR_BYTES = 2,
    parameter bit IS_SLAVE = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      valid,
    input  logic [8:0]                entry,
    output logic                      display_en,
    output logic                      write_strobe,
    output logic [7:0]                write_mode,
    output logic [8*WR_BYTES-1:0]     write_data,
    output logic                      draw_strobe,
    output logic                      draw_text,
    output logic [3:0]                draw_ops,
    output logic [8*DRAW_BYTES-1:0]   draw_par
);
    localparam int WCW = $clog2(WR_BYTES + 1);
    localparam int VIW = $clog2(DRAW_BYTES + 1);

    par_target_e            target;
    logic [WCW-1:0]         wr_cnt;
    logic [VIW-1:0]         vidx;
    logic [8*WR_BYTES-1:0]  wr_buf;
    logic [8*WR_BYTES-1:0]  wr_next;
    logic [7:0]             par [DRAW_BYTES];
    logic                   is_cmd;
    logic [7:0]             byte_in;
    logic                   wr_match;

    assign is_cmd   = entry[8];
    assign byte_in  = entry[7:0];
    assign wr_next  = {byte_in, wr_buf} >> 8;
    assign wr_match = IS_SLAVE && ((write_mode & WR_MASK) == WR_MATCH);

    // Flatten the parameter store onto the output bus
    for (genvar g = 0; g < DRAW_BYTES; g++) begin : g_flat
        assign draw_par[8*g +: 8] = par[g];
    end

    // Command decode and parameter routing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target       <= TGT_NONE;
            wr_cnt       <= '0;
            vidx         <= '0;
            wr_buf       <= '0;
            display_en   <= 1'b0;
            write_strobe <= 1'b0;
            write_mode   <= 8'h00;
            write_data   <= '0;
            draw_strobe  <= 1'b0;
            draw_text    <= 1'b0;
            draw_ops     <= 4'h0;
            for (int i = 0; i < DRAW_BYTES; i++)
                par[i] <= draw_default(i);
        end else begin
            write_strobe <= 1'b0;
            draw_strobe  <= 1'b0;
            if (valid && is_cmd) begin
                wr_cnt <= '0;
                vidx   <= '0;
                target <= TGT_NONE;
                if (byte_in[6:5] == 2'b01) begin
                    write_mode <= byte_in;
                    target     <= TGT_WRITE;
                end
                case (byte_in)
                    OP_START, OP_SYNC_ON:  display_en <= 1'b1;
                    OP_STOP, OP_SYNC_OFF:  display_en <= 1'b0;
                    OP_VSETUP:             target     <= TGT_VSETUP;
                    OP_FIGURE, OP_TEXT: begin
                        if (IS_SLAVE) begin
                            draw_strobe <= 1'b1;
                            draw_text   <= (byte_in == OP_TEXT);
                            draw_ops    <= par[0][6:3];
                            for (int i = 1; i < DRAW_BYTES; i++)
                                par[i] <= draw_default(i);
                        end
                    end
                    default: ;
                endcase
            end else if (valid) begin
                case (target)
                    TGT_WRITE: begin
                        wr_buf <= wr_next;
                        if (wr_cnt == WCW'(WR_BYTES - 1)) begin
                            wr_cnt <= '0;
                            if (wr_match) begin
                                write_strobe <= 1'b1;
                                write_data   <= wr_next;
                            end
                        end else begin
                            wr_cnt <= wr_cnt + 1'b1;
                        end
                    end
                    TGT_VSETUP: begin
                        if (vidx < VIW'(DRAW_BYTES)) begin
                            par[vidx] <= byte_in;
                            vidx      <= vidx + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/status_gen.sv
// Module: status_gen
// Builds the status byte from raster timing inputs and queue flags.
// Purely combinational; a raster period of zero reports no horizontal blank.
module status_gen #(
    parameter int TIME_W = 16
) (
    input  logic [TIME_W-1:0] raster_period,
    input  logic [TIME_W-1:0] hsync_period,
    input  logic [TIME_W-1:0] frame_remain,
    input  logic              vsync_in,
    input  logic              drawing_in,
    input  logic              q_empty,
    input  logic              q_full,
    output logic [7:0]        status
);
    logic [TIME_W-1:0] line_pos;
    logic              hblank;

    // Position within the current raster line and blank decision
    always_comb begin
        line_pos = (raster_period != '0) ? (frame_remain % raster_period) : '0;
        hblank   = (raster_period != '0) && (line_pos < hsync_period);
    end

    assign status = {1'b1, hblank, vsync_in, 1'b0, drawing_in, q_empty, q_full, 1'b0};

endmodule

// File: rtl/disp_cmd_front.sv
// Module: disp_cmd_front (top)
// Command and parameter ports feeding a flagged queue, a decoder and a status
// byte. Assumes the command port has priority when both ports write in the
// same cycle, and that the decoder is held while drawing_in is high.
module disp_cmd_front
    import disp_front_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int WR_BYTES   = 2,
    parameter int TIME_W     = 16,
    parameter bit IS_SLAVE   = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_wr,
    input  logic                     par_wr,
    input  logic [7:0]               wr_data,
    input  logic                     drawing_in,
    input  logic                     vsync_in,
    input  logic [TIME_W-1:0]        raster_period,
    input  logic [TIME_W-1:0]        hsync_period,
    input  logic [TIME_W-1:0]        frame_remain,
    output logic [7:0]               status,
    output logic                     display_en,
    output logic                     write_strobe,
    output logic [7:0]               write_mode,
    output logic [8*WR_BYTES-1:0]    write_data,
    output logic                     draw_strobe,
    output logic                     draw_text,
    output logic [3:0]               draw_ops,
    output logic [8*DRAW_BYTES-1:0]  draw_par
);
    logic [8:0] head;
    logic       q_empty, q_full, pop;

    assign pop = !q_empty && !drawing_in;

    cmd_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(9)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (cmd_wr || par_wr),
        .push_data ({cmd_wr, wr_data}),
        .pop       (pop),
        .head      (head),
        .empty     (q_empty),
        .full      (q_full)
    );

    front_decoder #(.WR_BYTES(WR_BYTES), .IS_SLAVE(IS_SLAVE)) u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid        (pop),
        .entry        (head),
        .display_en   (display_en),
        .write_strobe (write_strobe),
        .write_mode   (write_mode),
        .write_data   (write_data),
        .draw_strobe  (draw_strobe),
        .draw_text    (draw_text),
        .draw_ops     (draw_ops),
        .draw_par     (draw_par)
    );

    status_gen #(.TIME_W(TIME_W)) u_status (
        .raster_period (raster_period),
        .hsync_period  (hsync_period),
        .frame_remain  (frame_remain),
        .vsync_in      (vsync_in),
        .drawing_in    (drawing_in),
        .q_empty       (q_empty),
        .q_full        (q_full),
        .status        (status)
    );

endmodule

// File: rtl/disp_cmd_front_chk.sv
// Module: disp_cmd_front_chk
// Property checker bound to disp_cmd_front; observes ports only.
module disp_cmd_front_chk
    import disp_front_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     drawing_in,
    input logic                     vsync_in,
    input logic [7:0]               status,
    input logic                     display_en,
    input logic                     write_strobe,
    input logic [7:0]               write_mode,
    input logic                     draw_strobe,
    input logic [8*DRAW_BYTES-1:0]  draw_par
);
    localparam logic [8*DRAW_BYTES-1:0] DEFS = draw_defaults_flat();

    p_status_msb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status[7] && !status[4] && !status[0] && (status[5] == vsync_in));

    p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[1] && status[2]));

    p_write_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        write_strobe |-> ((write_mode & WR_MASK) == WR_MATCH));

    p_draw_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        draw_strobe |-> (draw_par[8*DRAW_BYTES-1:8] == DEFS[8*DRAW_BYTES-1:8]));

    p_one_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({write_strobe, draw_strobe}));

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        drawing_in |=> ($stable(display_en) && !write_strobe && !draw_strobe));

endmodule

bind disp_cmd_front disp_cmd_front_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .drawing_in   (drawing_in),
    .vsync_in     (vsync_in),
    .status       (status),
    .display_en   (display_en),
    .write_strobe (write_strobe),
    .write_mode   (write_mode),
    .draw_strobe  (draw_strobe),
    .draw_par     (draw_par)
);

// File: tb/disp_cmd_front_bench.sv
// Directed bench for disp_cmd_front: one task per scenario.
module disp_cmd_front_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0, par_wr = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        drawing_in = 1'b0, vsync_in = 1'b0;
    logic [15:0] raster_period = 16'd0, hsync_period = 16'd0, frame_remain = 16'd0;
    logic [7:0]  status;
    logic        display_en, write_strobe, draw_strobe, draw_text;
    logic [7:0]  write_mode;
    logic [15:0] write_data;
    logic [3:0]  draw_ops;
    logic [87:0] draw_par;

    int n_checks = 0, n_fail = 0;
    int wr_seen = 0, dr_seen = 0;
    logic [15:0] wr_last = 16'h0;
    logic [3:0]  ops_last = 4'h0;
    logic        text_last = 1'b0;
    bit          done = 1'b0;

    disp_cmd_front u_disp_cmd_front (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .par_wr(par_wr), .wr_data(wr_data),
        .drawing_in(drawing_in), .vsync_in(vsync_in), .raster_period(raster_period),
        .hsync_period(hsync_period), .frame_remain(frame_remain), .status(status),
        .display_en(display_en), .write_strobe(write_strobe), .write_mode(write_mode),
        .write_data(write_data), .draw_strobe(draw_strobe), .draw_text(draw_text),
        .draw_ops(draw_ops), .draw_par(draw_par)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Strobe monitor, sampled just after each rising edge
    always @(posedge clk) begin
        #1;
        if (write_strobe) begin wr_seen++; wr_last = write_data; end
        if (draw_strobe)  begin dr_seen++; ops_last = draw_ops; text_last = draw_text; end
    end

    function automatic logic [87:0] defaults(input logic [7:0] b0);
        logic [87:0] v;
        v = '0;
        v[7:0] = b0;
        v[31:24] = 8'h08; v[47:40] = 8'h08;
        v[87:56] = 32'hFFFF_FFFF;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [87:0] act, input logic [87:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_cmd(input logic [7:0] b);
        cmd_wr = 1'b1; wr_data = b; @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic push_par(input logic [7:0] b);
        par_wr = 1'b1; wr_data = b; @(negedge clk); par_wr = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        check(status == 8'h84, "R2 R8 reset status", status, 8'h84);
        check(display_en == 1'b0, "R9 reset display", display_en, 0);
        check(draw_par == defaults(8'h00), "R7 reset draw bytes", draw_par, defaults(8'h00));
        check(write_mode == 8'h00 && !write_strobe && !draw_strobe, "R4 reset strobes", write_mode, 0);
    endtask

    task automatic t_status;
        raster_period = 16'd100; hsync_period = 16'd10; frame_remain = 16'd205; vsync_in = 1'b1;
        #1 check(status == 8'hE4, "R8 hblank inside sync", status, 8'hE4);
        frame_remain = 16'd250;
        #1 check(status == 8'hA4, "R8 hblank outside sync", status, 8'hA4);
        raster_period = 16'd0; vsync_in = 1'b0;
        #1 check(status == 8'h84, "R8 zero raster period", status, 8'h84);
        @(negedge clk);
    endtask

    task automatic t_display;
        push_cmd(8'h6B); settle(2);
        check(display_en == 1'b1, "R9 start", display_en, 1);
        push_cmd(8'h0C); settle(2);
        check(display_en == 1'b0, "R9 stop", display_en, 0);
        push_cmd(8'h0F); settle(2);
        check(display_en == 1'b1, "R9 sync on", display_en, 1);
        push_cmd(8'h0E); settle(2);
        check(display_en == 1'b0, "R9 sync off", display_en, 0);
    endtask

    task automatic t_stall;
        drawing_in = 1'b1;
        push_cmd(8'h6B); settle(4);
        check(display_en == 1'b0, "R1 held while drawing", display_en, 0);
        check(status == 8'h88, "R1 R8 busy status not empty", status, 8'h88);
        drawing_in = 1'b0; settle(3);
        check(display_en == 1'b1, "R1 resumes after drawing", display_en, 1);
    endtask

    task automatic t_write;
        int base;
        base = wr_seen;
        push_cmd(8'h20); push_par(8'h34); push_par(8'h12); settle(3);
        check(wr_seen == base + 1 && wr_last == 16'h1234, "R4 first write group", wr_last, 16'h1234);
        check(write_mode == 8'h20, "R3 write mode latched", write_mode, 8'h20);
        push_par(8'h78); push_par(8'h56); settle(3);
        check(wr_seen == base + 2 && wr_last == 16'h5678, "R4 counter restarts", wr_last, 16'h5678);
        push_cmd(8'h24); push_par(8'h01); push_par(8'h02); settle(3);
        check(write_mode == 8'h24, "R3 mode 0x24 latched", write_mode, 8'h24);
        check(wr_seen == base + 2, "R4 mode 0x24 no strobe", wr_seen, base + 2);
    endtask

    task automatic t_figure;
        logic [87:0] exp;
        int base;
        base = dr_seen;
        push_cmd(8'h4C); push_par(8'h48);
        for (int i = 1; i <= 10; i++) push_par(8'hA0 + 8'(i));
        push_par(8'h55); settle(3);
        exp[7:0] = 8'h48;
        for (int i = 1; i <= 10; i++) exp[8*i +: 8] = 8'hA0 + 8'(i);
        check(draw_par == exp, "R5 vector setup fill and extra ignored", draw_par, exp);
        push_cmd(8'h6C); settle(3);
        check(dr_seen == base + 1 && ops_last == 4'b1001 && !text_last, "R6 figure ops line+rect",
              ops_last, 4'b1001);
        check(draw_par == defaults(8'h48), "R7 restore after figure", draw_par, defaults(8'h48));
    endtask

    task automatic t_text;
        int base;
        base = dr_seen;
        push_cmd(8'h4C); push_par(8'h30); push_par(8'h77); push_cmd(8'h68); settle(3);
        check(dr_seen == base + 1 && ops_last == 4'b0110 && text_last, "R6 text ops text+arc",
              ops_last, 4'b0110);
        check(draw_par == defaults(8'h30), "R7 restore after text", draw_par, defaults(8'h30));
    endtask

    task automatic t_overflow;
        int base;
        base = wr_seen;
        drawing_in = 1'b1;
        push_cmd(8'h20);
        for (int i = 0; i < 17; i++) push_par(8'h10 + 8'(i));
        check(status[1] == 1'b1 && status[2] == 1'b0, "R2 full flag", status, 8'h8A);
        drawing_in = 1'b0; settle(20);
        check(wr_seen == base + 7, "R2 groups from 15 kept bytes", wr_seen, base + 7);
        push_par(8'hEE); settle(3);
        check(wr_last == 16'hEE1E, "R2 dropped bytes absent", wr_last, 16'hEE1E);
        check(status[2] == 1'b1, "R2 empty after drain", status, 8'h84);
    endtask

    task automatic t_both_ports;
        drawing_in = 1'b1;
        for (int i = 0; i < 15; i++) begin
            cmd_wr = 1'b1; par_wr = 1'b1; wr_data = 8'h0E; @(negedge clk);
        end
        cmd_wr = 1'b0; par_wr = 1'b0;
        check(status[1] == 1'b0, "R1 one entry per dual write", status, 8'h88);
        push_cmd(8'h0E);
        check(status[1] == 1'b1, "R1 R2 full at sixteen", status, 8'h8A);
        drawing_in = 1'b0; settle(20);
        check(display_en == 1'b0, "R1 command side kept", display_en, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status();
        t_display();
        t_stall();
        t_write();
        t_figure();
        t_text();
        t_overflow();
        t_both_ports();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule